// File: doc/BRIEF.md
# PHY Discovery and Link Resolver

This block finds an Ethernet PHY on a management bus, works out which kind of PHY it is, waits for its link to come up, and turns the PHY's own status register into a line speed and a duplex mode. It does not shift bits on the serial management wires. It drives a simple register-read port that an external management master serves. Each read is a request with a PHY address and a register number, held until the master returns one acknowledge cycle with the 16-bit data.

A one-cycle `start` pulse begins a run. The sequencer probes addresses in turn until one answers, then reads that PHY's identifier to pick a decoding rule. It then polls the link bit, with a configurable idle gap between attempts and a configurable attempt limit. When the link is up, it reads the vendor status register that the identifier selects. The results stay on the outputs until the next run. The speed and duplex results are also merged into a MAC configuration word supplied by the surrounding logic.

Top module: `phy_link_resolver`

## Requirements
- R1: After `start`, register 1 is read at PHY addresses 1, 2, 3 … 31 strictly in increasing order. The first address whose reply is neither 0xFFFF nor 0x0000 is taken as the PHY, `found` goes high, `phy_addr` shows that address, and no further address is probed.
- R2: If no address from 1 to 31 answers, the run ends with `done` high, `found` low, `link_ok` low, `phy_type` 0, `speed` 0 and `duplex` 0.
- R3: Register 2 of the found PHY sets `phy_type`: 0x0016 gives 1, 0x0022 gives 2, 0x0141 gives 3, 0x0302 gives 4, 0x0013 gives 5, and any other value gives 7.
- R4: The link is up when bit 2 of register 1 is set. At most POLL_LIMIT link reads are made. Between two link reads no request is issued for POLL_GAP cycles. If all POLL_LIMIT reads show the link down, the run ends with `link_ok` low and `speed`/`duplex` 0.
- R5: For type 1 the resolver reads register 18. Bit 7 set gives 100M, otherwise 10M. Bit 6 set gives full duplex, otherwise half.
- R6: For types 2 and 4 the resolver reads register 18. Bit 10 set gives 100M, otherwise 10M. Bit 11 set gives full duplex, otherwise half.
- R7: For type 3 the resolver reads register 17. Bits 15:14 equal to 2'b10 give 1000M, 2'b01 give 100M, and any other value gives 10M. Bit 13 set gives full duplex.
- R8: For type 5 the resolver reads register 17. Bits 15:14 equal to 2'b11 give 1000M, 2'b10 give 100M, and any other value gives 10M. Bit 9 set gives full duplex.
- R9: For type 7, a link-up read ends the run at once with `link_ok` high, no vendor register read, and `speed`/`duplex` left at 0.
- R10: `speed` encodes 1 = 10M, 2 = 100M, 3 = 1000M, and 0 = unresolved. `duplex` encodes 1 = half, 2 = full, and 0 = unresolved. `cfg_out` equals `cfg_in` with bits 16, 19 and 20 replaced. Bit 19 is set only for 10M, bit 16 only for 1000M, and bit 20 only for full duplex.
- R11: A request holds `rd_req`, `rd_phy` and `rd_reg` steady until `rd_ack`. `rd_data` is used only in the acknowledge cycle.
- R12: `start` while `busy` is high has no effect on the run in progress. A new run clears all results of the previous one.
- R13: After reset, `busy`, `done`, `found`, `link_ok` and `rd_req` are low, and `phy_type`, `speed`, `duplex` and `phy_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a discovery run |
| rd_req | output | 1 | Register read request to the management master |
| rd_phy | output | 5 | PHY address of the request |
| rd_reg | output | 5 | Register number of the request |
| rd_ack | input | 1 | One-cycle acknowledge carrying read data |
| rd_data | input | 16 | Read data, valid with `rd_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has finished; held until next start |
| found | output | 1 | A PHY answered the scan |
| phy_addr | output | 5 | Address of the found PHY, 0 if none |
| phy_type | output | 3 | Classified PHY kind (R3) |
| link_ok | output | 1 | Link confirmed up |
| speed | output | 2 | Resolved speed code (R10) |
| duplex | output | 2 | Resolved duplex code (R10) |
| cfg_in | input | 32 | MAC configuration word from surrounding logic |
| cfg_out | output | 32 | Configuration word with speed and duplex bits applied |

## Verification
The assertions check properties that must hold on every cycle:
- the request stays steady until it is acknowledged;
- the address range is respected, and each failed probe moves the scan to the next address;
- a failed link poll is followed by a quiet gap;
- a run that finds no PHY ends clean;
- `cfg_out` always matches `speed` and `duplex` while its other bits track `cfg_in`.

Only the bench scenarios can show the rest:
- the identifier classification and the per-vendor choice of status register and bit positions;
- the exact number of link polls before giving up;
- that a second `start` mid-run changes nothing;
- the full results of a run against a modelled PHY.

// File: rtl/phy_res_pkg.sv
package phy_res_pkg;

    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_A     = 3'd1,
        PK_B     = 3'd2,
        PK_C     = 3'd3,
        PK_D     = 3'd4,
        PK_E     = 3'd5,
        PK_OTHER = 3'd7
    } phy_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SCAN,
        SQ_IDENT,
        SQ_LINK,
        SQ_GAP,
        SQ_STAT
    } seq_state_e;

    localparam logic [1:0] SPD_NONE = 2'd0;
    localparam logic [1:0] SPD_10   = 2'd1;
    localparam logic [1:0] SPD_100  = 2'd2;
    localparam logic [1:0] SPD_1000 = 2'd3;

    localparam logic [1:0] DPX_NONE = 2'd0;
    localparam logic [1:0] DPX_HALF = 2'd1;
    localparam logic [1:0] DPX_FULL = 2'd2;

    localparam logic [4:0] REG_BSTAT = 5'd1;
    localparam logic [4:0] REG_IDENT = 5'd2;
    localparam logic [4:0] REG_V17   = 5'd17;
    localparam logic [4:0] REG_V18   = 5'd18;

    localparam int LINK_BIT = 2;

endpackage

// File: rtl/phy_id_classify.sv
module phy_id_classify
    import phy_res_pkg::*;
(
    input  logic [15:0] id_word,
    output phy_kind_e   kind
);
    always_comb begin
        unique case (id_word)
            16'h0016: kind = PK_A;
            16'h0022: kind = PK_B;
            16'h0141: kind = PK_C;
            16'h0302: kind = PK_D;
            16'h0013: kind = PK_E;
            default:  kind = PK_OTHER;
        endcase
    end
endmodule

// File: rtl/phy_vendor_decode.sv
module phy_vendor_decode
    import phy_res_pkg::*;
(
    input  phy_kind_e   kind,
    input  logic [15:0] stat_word,
    output logic [4:0]  stat_reg,
    output logic [1:0]  spd,
    output logic [1:0]  dpx
);
    always_comb begin
        stat_reg = REG_V18;
        spd      = SPD_NONE;
        dpx      = DPX_NONE;
        unique case (kind)
            PK_A: begin
                stat_reg = REG_V18;
                spd      = stat_word[7] ? SPD_100 : SPD_10;
                dpx      = stat_word[6] ? DPX_FULL : DPX_HALF;
            end
            PK_B, PK_D: begin
                stat_reg = REG_V18;
                spd      = stat_word[10] ? SPD_100 : SPD_10;
                dpx      = stat_word[11] ? DPX_FULL : DPX_HALF;
            end
            PK_C: begin
                stat_reg = REG_V17;
                unique case (stat_word[15:14])
                    2'b10:   spd = SPD_1000;
                    2'b01:   spd = SPD_100;
                    default: spd = SPD_10;
                endcase
                dpx = stat_word[13] ? DPX_FULL : DPX_HALF;
            end
            PK_E: begin
                stat_reg = REG_V17;
                unique case (stat_word[15:14])
                    2'b11:   spd = SPD_1000;
                    2'b10:   spd = SPD_100;
                    default: spd = SPD_10;
                endcase
                dpx = stat_word[9] ? DPX_FULL : DPX_HALF;
            end
            default: begin
                stat_reg = REG_V18;
                spd      = SPD_NONE;
                dpx      = DPX_NONE;
            end
        endcase
    end
endmodule

// File: rtl/mac_cfg_merge.sv
module mac_cfg_merge
    import phy_res_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int POS_10M  = 19,
    parameter int POS_1000 = 16,
    parameter int POS_FULL = 20
) (
    input  logic [CFG_W-1:0] cfg_in,
    input  logic [1:0]       spd,
    input  logic [1:0]       dpx,
    output logic [CFG_W-1:0] cfg_out
);
    localparam logic [CFG_W-1:0] ONE       = {{(CFG_W-1){1'b0}}, 1'b1};
    localparam logic [CFG_W-1:0] MASK_10M  = ONE << POS_10M;
    localparam logic [CFG_W-1:0] MASK_1000 = ONE << POS_1000;
    localparam logic [CFG_W-1:0] MASK_FULL = ONE << POS_FULL;
    localparam logic [CFG_W-1:0] MASK_ALL  = MASK_10M | MASK_1000 | MASK_FULL;

    always_comb begin
        cfg_out = cfg_in & ~MASK_ALL;
        if (spd == SPD_10)   cfg_out = cfg_out | MASK_10M;
        if (spd == SPD_1000) cfg_out = cfg_out | MASK_1000;
        if (dpx == DPX_FULL) cfg_out = cfg_out | MASK_FULL;
    end
endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
    import phy_res_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int FIRST_ADDR = 1,
    parameter int LAST_ADDR  = 31,
    parameter int POLL_LIMIT = 4096,
    parameter int POLL_GAP   = 1000,
    parameter int CFG_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_phy,
    output logic [4:0]        rd_reg,
    input  logic              rd_ack,
    input  logic [15:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [2:0]        phy_type,
    output logic              link_ok,
    output logic [1:0]        speed,
    output logic [1:0]        duplex,
    input  logic [CFG_W-1:0]  cfg_in,
    output logic [CFG_W-1:0]  cfg_out
);
    localparam int TRY_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam logic [TRY_W-1:0]  TRY_LAST = TRY_W'(POLL_LIMIT - 1);
    localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(POLL_GAP - 1);
    localparam logic [ADDR_W-1:0] ADR_FST  = ADDR_W'(FIRST_ADDR);
    localparam logic [ADDR_W-1:0] ADR_LST  = ADDR_W'(LAST_ADDR);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [TRY_W-1:0]  tries;
        logic [GAP_W-1:0]  gap;
        logic              found;
        logic              done;
        logic              link;
        phy_kind_e         kind;
        logic [1:0]        spd;
        logic [1:0]        dpx;
    } seq_t;

    seq_t q, d;

    phy_kind_e  id_kind;
    logic [4:0] vend_reg;
    logic [1:0] vend_spd;
    logic [1:0] vend_dpx;
    logic       req_c;
    logic [4:0] reg_c;
    logic       answered;

    phy_id_classify u_classify (
        .id_word (rd_data),
        .kind    (id_kind)
    );

    phy_vendor_decode u_vendor (
        .kind      (q.kind),
        .stat_word (rd_data),
        .stat_reg  (vend_reg),
        .spd       (vend_spd),
        .dpx       (vend_dpx)
    );

    mac_cfg_merge #(
        .CFG_W (CFG_W)
    ) u_cfg (
        .cfg_in  (cfg_in),
        .spd     (q.spd),
        .dpx     (q.dpx),
        .cfg_out (cfg_out)
    );

    assign answered = (rd_data != 16'hFFFF) && (rd_data != 16'h0000);

    always_comb begin
        d     = q;
        req_c = 1'b0;
        reg_c = REG_BSTAT;
        unique case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.st    = SQ_SCAN;
                    d.addr  = ADR_FST;
                    d.tries = '0;
                    d.gap   = '0;
                    d.found = 1'b0;
                    d.done  = 1'b0;
                    d.link  = 1'b0;
                    d.kind  = PK_NONE;
                    d.spd   = SPD_NONE;
                    d.dpx   = DPX_NONE;
                end
            end
            SQ_SCAN: begin
                req_c = 1'b1;
                reg_c = REG_BSTAT;
                if (rd_ack) begin
                    if (answered) begin
                        d.found = 1'b1;
                        d.st    = SQ_IDENT;
                    end else if (q.addr == ADR_LST) begin
                        d.done = 1'b1;
                        d.st   = SQ_IDLE;
                    end else begin
                        d.addr = q.addr + 1'b1;
                    end
                end
            end
            SQ_IDENT: begin
                req_c = 1'b1;
                reg_c = REG_IDENT;
                if (rd_ack) begin
                    d.kind  = id_kind;
                    d.tries = '0;
                    d.st    = SQ_LINK;
                end
            end
            SQ_LINK: begin
                req_c = 1'b1;
                reg_c = REG_BSTAT;
                if (rd_ack) begin
                    if (rd_data[LINK_BIT]) begin
                        if (q.kind == PK_OTHER) begin
                            d.link = 1'b1;
                            d.done = 1'b1;
                            d.st   = SQ_IDLE;
                        end else begin
                            d.st = SQ_STAT;
                        end
                    end else if (q.tries == TRY_LAST) begin
                        d.done = 1'b1;
                        d.st   = SQ_IDLE;
                    end else begin
                        d.tries = q.tries + 1'b1;
                        d.gap   = '0;
                        d.st    = SQ_GAP;
                    end
                end
            end
            SQ_GAP: begin
                if (q.gap == GAP_LAST) begin
                    d.st = SQ_LINK;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            SQ_STAT: begin
                req_c = 1'b1;
                reg_c = vend_reg;
                if (rd_ack) begin
                    d.spd  = vend_spd;
                    d.dpx  = vend_dpx;
                    d.link = 1'b1;
                    d.done = 1'b1;
                    d.st   = SQ_IDLE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= SQ_IDLE;
            q.addr  <= '0;
            q.tries <= '0;
            q.gap   <= '0;
            q.found <= 1'b0;
            q.done  <= 1'b0;
            q.link  <= 1'b0;
            q.kind  <= PK_NONE;
            q.spd   <= SPD_NONE;
            q.dpx   <= DPX_NONE;
        end else begin
            q <= d;
        end
    end

    assign rd_req   = req_c;
    assign rd_reg   = reg_c;
    assign rd_phy   = q.addr;
    assign busy     = (q.st != SQ_IDLE);
    assign done     = q.done;
    assign found    = q.found;
    assign phy_addr = q.found ? q.addr : '0;
    assign phy_type = q.kind;
    assign link_ok  = q.link;
    assign speed    = q.spd;
    assign duplex   = q.dpx;

endmodule

// File: rtl/phy_link_resolver_chk.sv
module phy_link_resolver_chk #(
    parameter int ADDR_W     = 5,
    parameter int FIRST_ADDR = 1,
    parameter int LAST_ADDR  = 31,
    parameter int CFG_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_phy,
    input logic [4:0]        rd_reg,
    input logic              rd_ack,
    input logic [15:0]       rd_data,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic [2:0]        phy_type,
    input logic              link_ok,
    input logic [1:0]        speed,
    input logic [1:0]        duplex,
    input logic [CFG_W-1:0]  cfg_in,
    input logic [CFG_W-1:0]  cfg_out
);
    localparam logic [CFG_W-1:0] ONE  = {{(CFG_W-1){1'b0}}, 1'b1};
    localparam logic [CFG_W-1:0] KEEP = ~((ONE << 16) | (ONE << 19) | (ONE << 20));

    // R11: request fields stay put until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_phy) && $stable(rd_reg));

    // R1: only addresses inside the scan window are ever requested
    a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_phy >= ADDR_W'(FIRST_ADDR)) && (rd_phy <= ADDR_W'(LAST_ADDR)));

    // R1: an empty probe moves straight on to the next address
    a_r1_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && rd_reg == 5'd1 && !found &&
        (rd_data == 16'hFFFF || rd_data == 16'h0000) && rd_phy != ADDR_W'(LAST_ADDR)
        |=> rd_req && rd_reg == 5'd1 && rd_phy == $past(rd_phy) + 1'b1);

    // R2: a run that found nothing leaves every result cleared
    a_r2_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
        done && !found |-> !link_ok && phy_type == 3'd0 && speed == 2'd0 && duplex == 2'd0);

    // R4: a failed link poll is followed by a quiet cycle
    a_r4_poll_gap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && rd_reg == 5'd1 && found && !rd_data[2] |=> !rd_req);

    // R9: link can only be reported for a found PHY
    a_r9_link_needs_phy: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok |-> found);

    // R10: resolved speed implies link
    a_r10_speed_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        speed != 2'd0 |-> link_ok && duplex != 2'd0);

    // R10: configuration word bits follow the resolved values
    a_r10_cfg_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out[19] == (speed == 2'd1)) && (cfg_out[16] == (speed == 2'd3)) &&
        (cfg_out[20] == (duplex == 2'd2)) && ((cfg_out & KEEP) == (cfg_in & KEEP)));

    // R12: done and busy never overlap
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: requests only while busy
    a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

endmodule

bind phy_link_resolver phy_link_resolver_chk #(
    .ADDR_W     (ADDR_W),
    .FIRST_ADDR (FIRST_ADDR),
    .LAST_ADDR  (LAST_ADDR),
    .CFG_W      (CFG_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_phy   (rd_phy),
    .rd_reg   (rd_reg),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .phy_type (phy_type),
    .link_ok  (link_ok),
    .speed    (speed),
    .duplex   (duplex),
    .cfg_in   (cfg_in),
    .cfg_out  (cfg_out)
);

// File: tb/phy_link_resolver_tb_top.sv
`timescale 1ns/1ps
module phy_link_resolver_tb_top;

    localparam int PL = 6;
    localparam int PG = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req;
    logic [4:0]  rd_phy;
    logic [4:0]  rd_reg;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic        busy, done, found, link_ok;
    logic [4:0]  phy_addr;
    logic [2:0]  phy_type;
    logic [1:0]  speed, duplex;
    logic [31:0] cfg_in = 32'h0;
    logic [31:0] cfg_out;

    always #10 clk = ~clk;

    phy_link_resolver #(.POLL_LIMIT(PL), .POLL_GAP(PG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .found(found), .phy_addr(phy_addr),
        .phy_type(phy_type), .link_ok(link_ok), .speed(speed), .duplex(duplex),
        .cfg_in(cfg_in), .cfg_out(cfg_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    // PHY model state
    int          m_addr;
    logic [15:0] m_id;
    logic [15:0] m_stat;
    int          m_up_after;
    int          link_reads;
    int          vend_reg_seen;
    int          next_scan;
    bit          id_seen;
    bit          scan_bad;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_kind(input logic [15:0] id);
        case (id)
            16'h0016: return 3'd1;
            16'h0022: return 3'd2;
            16'h0141: return 3'd3;
            16'h0302: return 3'd4;
            16'h0013: return 3'd5;
            default:  return 3'd7;
        endcase
    endfunction

    // returns {register, speed, duplex}
    function automatic logic [8:0] exp_res(input logic [2:0] k, input logic [15:0] s);
        logic [1:0] sp, dx;
        int rg;
        sp = 0; dx = 0; rg = 0;
        case (k)
            3'd1: begin rg = 18; sp = s[7] ? 2 : 1; dx = s[6] ? 2 : 1; end
            3'd2, 3'd4: begin rg = 18; sp = s[10] ? 2 : 1; dx = s[11] ? 2 : 1; end
            3'd3: begin
                rg = 17;
                sp = (s[15:14] == 2'b10) ? 2'd3 : (s[15:14] == 2'b01) ? 2'd2 : 2'd1;
                dx = s[13] ? 2 : 1;
            end
            3'd5: begin
                rg = 17;
                sp = (s[15:14] == 2'b11) ? 2'd3 : (s[15:14] == 2'b10) ? 2'd2 : 2'd1;
                dx = s[9] ? 2 : 1;
            end
            default: ;
        endcase
        return {rg[4:0], sp, dx};
    endfunction

    function automatic logic [31:0] exp_cfg(input logic [31:0] c, input logic [1:0] sp, input logic [1:0] dx);
        logic [31:0] r;
        r = c & ~32'h0019_0000;
        if (sp == 2'd1) r[19] = 1'b1;
        if (sp == 2'd3) r[16] = 1'b1;
        if (dx == 2'd2) r[20] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] model_reply(input int a, input int rg);
        if (a == m_addr) begin
            if (rg == 1) begin
                if (!id_seen) return 16'h7809;
                return (link_reads > m_up_after) ? 16'h782D : 16'h7809;
            end
            if (rg == 2) return m_id;
            if (rg == 17 || rg == 18) return m_stat;
            return 16'h0000;
        end
        return a[0] ? 16'hFFFF : 16'h0000;
    endfunction

    // management master model
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req && rst_n) begin
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    rd_data = 16'($urandom);
                end
                if (int'(rd_reg) == 1 && !id_seen) begin
                    if (int'(rd_phy) != next_scan) scan_bad = 1;
                    next_scan++;
                end
                if (int'(rd_reg) == 1 && id_seen) link_reads++;
                if (int'(rd_reg) == 17 || int'(rd_reg) == 18) vend_reg_seen = int'(rd_reg);
                rd_data = model_reply(int'(rd_phy), int'(rd_reg));
                if (int'(rd_reg) == 2 && int'(rd_phy) == m_addr) id_seen = 1;
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
                rd_data = 16'($urandom);
            end
        end
    end

    task automatic run_case(input int a, input logic [15:0] id, input logic [15:0] st,
                            input int up_after, input bit restart_mid);
        logic [2:0] k;
        logic [8:0] r;
        bit         up;
        int         cyc;
        m_addr = a; m_id = id; m_stat = st; m_up_after = up_after;
        link_reads = 0; vend_reg_seen = 0; next_scan = 1; id_seen = 0; scan_bad = 0;
        cfg_in = $urandom;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R12 busy after start", 32'(busy), 1);
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (restart_mid && cyc == 40) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        k  = exp_kind(id);
        r  = exp_res(k, st);
        up = (up_after < PL);
        check(done === 1'b1, "R12 done", 32'(done), 1);
        check(scan_bad == 0, "R1 scan order", 32'(scan_bad), 0);
        if (a == 0) begin
            check(found === 1'b0, "R2 found", 32'(found), 0);
            check(next_scan == 32, "R2 all addresses", 32'(next_scan), 32);
            check({link_ok, phy_type, speed, duplex} === 8'h0, "R2 results",
                  32'({link_ok, phy_type, speed, duplex}), 0);
        end else begin
            check(found === 1'b1 && phy_addr === 5'(a), "R1 phy addr", 32'(phy_addr), 32'(a));
            check(next_scan == a + 1, "R1 scan stopped", 32'(next_scan), 32'(a + 1));
            check(phy_type === k, "R3 type", 32'(phy_type), 32'(k));
            if (!up) begin
                check(link_reads == PL, "R4 poll count", 32'(link_reads), PL);
                check({link_ok, speed, duplex} === 5'h0, "R4 link down", 32'({link_ok, speed, duplex}), 0);
            end else begin
                check(link_reads == up_after + 1, "R4 polls to link", 32'(link_reads), 32'(up_after + 1));
                check(link_ok === 1'b1, "R4 link up", 32'(link_ok), 1);
                if (k == 3'd7) begin
                    check(vend_reg_seen == 0 && speed == 0 && duplex == 0, "R9 other kind",
                          32'({vend_reg_seen[4:0], speed, duplex}), 0);
                end else begin
                    check(vend_reg_seen == int'(r[8:4]), "R5 R6 R7 R8 status register",
                          32'(vend_reg_seen), 32'(r[8:4]));
                    check(speed === r[3:2], "R5 R6 R7 R8 speed", 32'(speed), 32'(r[3:2]));
                    check(duplex === r[1:0], "R5 R6 R7 R8 duplex", 32'(duplex), 32'(r[1:0]));
                end
            end
        end
        check(cfg_out === exp_cfg(cfg_in, speed, duplex), "R10 cfg word", cfg_out,
              exp_cfg(cfg_in, speed, duplex));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] ids [6];
        void'($urandom(32'd2024));
        ids[0] = 16'h0016; ids[1] = 16'h0022; ids[2] = 16'h0141;
        ids[3] = 16'h0302; ids[4] = 16'h0013; ids[5] = 16'hABC0;
        m_addr = 0; m_id = 0; m_stat = 0; m_up_after = 0;
        link_reads = 0; vend_reg_seen = 0; next_scan = 1; id_seen = 1; scan_bad = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check({busy, done, found, link_ok, rd_req} === 5'b0, "R13 reset flags",
              32'({busy, done, found, link_ok, rd_req}), 0);
        check({phy_type, speed, duplex, phy_addr} === 12'h0, "R13 reset values",
              32'({phy_type, speed, duplex, phy_addr}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_case(1,  16'h0016, 16'h00C0, 0, 0);   // R5 100M full at first address
        run_case(31, 16'h0016, 16'h0000, 1, 0);   // R5 10M half at last address
        run_case(0,  16'h0016, 16'h0000, 0, 0);   // R2 nothing present
        run_case(5,  16'h0022, 16'h0800, 2, 0);   // R6 10M full
        run_case(6,  16'h0302, 16'h0400, 0, 0);   // R6 100M half
        run_case(7,  16'h0141, 16'hA000, 0, 0);   // R7 1000M full
        run_case(8,  16'h0141, 16'hC000, 0, 0);   // R7 11 -> 10M
        run_case(9,  16'h0013, 16'hC200, 0, 0);   // R8 1000M full
        run_case(10, 16'h0013, 16'h4000, 0, 0);   // R8 01 -> 10M
        run_case(11, 16'h1234, 16'hFFFF, 1, 0);   // R9 unknown kind
        run_case(12, 16'h0141, 16'h4000, PL, 0);  // R4 link never up
        run_case(13, 16'h0022, 16'h0C00, 3, 1);   // R12 start mid-run ignored

        // random mix
        for (int i = 0; i < 40; i++) begin
            int a;
            a = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 31);
            run_case(a, ids[$urandom % 6], 16'($urandom), int'($urandom % (PL + 2)), 0);
        end

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule